// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Flags

This block is a first-in first-out buffer with 9-bit words. The write side and the read side each run on their own free-running clock and do not depend on each other. A word enters on a write-clock edge when both write enables are active. A word leaves on a read-clock edge when both read enables are active. An active-low output enable qualifies the read data bus. The block reports four active-low status flags: Empty and Almost-Empty on the read clock, and Full and Almost-Full on the write clock.

The two almost thresholds are held in offset registers. These registers are loaded at run time through the write port while the load strobe is low. Each pointer is passed to the other clock domain as a Gray-coded value through a two-stage synchronizer. The depth is a power-of-two parameter from 512 to 8192 words.

The offsets are treated as quasi-static: they are loaded while the read side is idle and then read directly by the read-side flag logic.

Top module: `dcf_fifo_pflag`

## Requirements
- R1: A word is stored only on a write-clock edge where wr_en_n is low, wr_en is high, ld_n is high and the FIFO is not full; with just one of the two enables active, nothing is stored.
- R2: A read happens on a read-clock edge where rd_en_n is low, rd_en is high and the FIFO is not empty; the word appears on rd_data from that edge on, in the order the words were written.
- R3: A write attempted while full_n is low is dropped, and a read attempted while empty_n is low leaves the FIFO unchanged.
- R4: empty_n is low while the read side sees no stored words. It goes high within three read-clock edges after a write lands, and low on the read edge that removes the last word.
- R5: full_n goes low on the write edge that stores word number DEPTH and stays high for any smaller count.
- R6: almost_empty_n is low whenever the read-side word count is at most the almost-empty offset.
- R7: almost_full_n is low whenever DEPTH minus the write-side word count is at most the almost-full offset.
- R8: While ld_n is low, each write edge with both enables active stores the data bus into the offset registers instead of the FIFO. The order is: all 9-bit pieces of the almost-empty offset, lowest piece first, then all pieces of the almost-full offset. Raising ld_n restarts this sequence at the first piece.
- R9: When oe_n is high, rd_oe is low and rd_data reads zero. When oe_n is low, rd_oe is high and rd_data shows the last word read.
- R10: When rst_n is low, both pointers clear and both offsets return to 7. empty_n and almost_empty_n go low, and full_n and almost_full_n go high.
- R11: Each pointer's Gray code changes by at most one bit per edge of its own clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write-side clock |
| rd_clk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en_n | input | 1 | Write enable, active low |
| wr_en | input | 1 | Write enable, active high |
| ld_n | input | 1 | Offset load strobe, active low |
| wr_data | input | 9 | Write data, or an offset piece during a load |
| rd_en_n | input | 1 | Read enable, active low |
| rd_en | input | 1 | Read enable, active high |
| oe_n | input | 1 | Output enable, active low |
| rd_data | output | 9 | Read data, zero while the output is disabled |
| rd_oe | output | 1 | High while rd_data is driven |
| empty_n | output | 1 | Empty flag, active low, read domain |
| almost_empty_n | output | 1 | Almost-empty flag, active low, read domain |
| almost_full_n | output | 1 | Almost-full flag, active low, write domain |
| full_n | output | 1 | Full flag, active low, write domain |

## Verification
The assertions check four properties on every cycle. Neither pointer moves on an attempted overflow or underflow, or during an offset load. Each Gray pointer steps by one bit at most. The write-side count never exceeds the depth. Full implies almost-full, and empty implies almost-empty.

Other behaviour can only be shown by the bench's scenarios, because it depends on data flowing across the two clocks. These include word ordering through the scoreboard and the exact counts where each flag changes. They also include the piece order of the offset load, gating of the output, and recovery of the default offsets after a reset.

// File: rtl/dcf_pkg.sv
package dcf_pkg;
  localparam int WORD_W    = 9;
  localparam int OFF_RESET = 7;

  // number of 9-bit pieces needed for one offset of aw bits
  function automatic int piece_count(input int aw);
    return (aw + WORD_W - 1) / WORD_W;
  endfunction

  // width of the load slot counter (two offsets of piece_count pieces)
  function automatic int slot_width(input int aw);
    int n;
    n = 2 * piece_count(aw);
    return (n <= 2) ? 1 : $clog2(n);
  endfunction
endpackage

// File: rtl/dcf_gray_sync.sv
module dcf_gray_sync #(
  parameter int W      = 10,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] gray_in,
  output logic [W-1:0] bin_out
);
  logic [W-1:0] stage_q [STAGES];

  function automatic logic [W-1:0] gray_to_bin(input logic [W-1:0] g);
    logic [W-1:0] b;
    b[W-1] = g[W-1];
    for (int i = W - 2; i >= 0; i--) b[i] = b[i+1] ^ g[i];
    return b;
  endfunction

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= gray_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage_q[s] <= '0;
          else        stage_q[s] <= stage_q[s-1];
        end
      end
    end
  endgenerate

  assign bin_out = gray_to_bin(stage_q[STAGES-1]);
endmodule

// File: rtl/dcf_mem.sv
module dcf_mem #(
  parameter int AW = 9,
  parameter int W  = 9
) (
  input  logic          wclk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic          rclk,
  input  logic          rst_n,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [W-1:0]  rdata
);
  localparam int DEPTH = 1 << AW;

  logic [W-1:0] store [DEPTH];

  always_ff @(posedge wclk) begin
    if (we) store[waddr] <= wdata;
  end

  always_ff @(posedge rclk or negedge rst_n) begin
    if (!rst_n)  rdata <= '0;
    else if (re) rdata <= store[raddr];
  end
endmodule

// File: rtl/dcf_wr_ctrl.sv
module dcf_wr_ctrl
  import dcf_pkg::*;
#(
  parameter int AW = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              wr_en,
  input  logic              ld_n,
  input  logic [WORD_W-1:0] din,
  input  logic [AW:0]       rbin_s,
  output logic [AW:0]       wbin,
  output logic [AW:0]       wgray,
  output logic              mem_we,
  output logic [AW-1:0]     mem_waddr,
  output logic              full,
  output logic              afull,
  output logic [AW-1:0]     ae_off,
  output logic [AW-1:0]     af_off
);
  localparam int CW    = AW + 1;
  localparam int DEPTH = 1 << AW;
  localparam int NP    = piece_count(AW);
  localparam int NSLOT = 2 * NP;
  localparam int SLW   = slot_width(AW);
  localparam int RAWW  = NP * WORD_W;

  function automatic logic [CW-1:0] bin_to_gray(input logic [CW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CW-1:0] used_words(input logic [CW-1:0] wp,
                                              input logic [CW-1:0] rp);
    return wp - rp;
  endfunction

  function automatic logic below_or_at(input logic [CW-1:0] v,
                                       input logic [AW-1:0] lim);
    return v <= {1'b0, lim};
  endfunction

  // named events
  logic          both_en;
  logic          wr_req;
  logic          wr_acc;
  logic          ld_fire;
  logic [CW-1:0] wbin_nxt;
  logic [CW-1:0] wcount;
  logic [CW-1:0] wfree;

  logic [SLW-1:0]  slot_q;
  logic [RAWW-1:0] ae_raw;
  logic [RAWW-1:0] af_raw;

  assign both_en  = !wr_en_n && wr_en;
  assign wr_req   = both_en && ld_n;
  assign wr_acc   = wr_req && !full;
  assign ld_fire  = both_en && !ld_n;
  assign wbin_nxt = wbin + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wbin  <= '0;
      wgray <= '0;
    end else if (wr_acc) begin
      wbin  <= wbin_nxt;
      wgray <= bin_to_gray(wbin_nxt);
    end
  end

  assign mem_we    = wr_acc;
  assign mem_waddr = wbin[AW-1:0];

  assign wcount = used_words(wbin, rbin_s);
  assign wfree  = CW'(DEPTH) - wcount;
  assign full   = (wcount == CW'(DEPTH));
  assign afull  = below_or_at(wfree, af_off);

  // offset loading: almost-empty pieces first, then almost-full, low piece first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      slot_q <= '0;
      ae_raw <= RAWW'(OFF_RESET);
      af_raw <= RAWW'(OFF_RESET);
    end else if (!ld_n) begin
      if (ld_fire) begin
        for (int p = 0; p < NP; p++) begin
          if (slot_q == SLW'(p))      ae_raw[p*WORD_W +: WORD_W] <= din;
          if (slot_q == SLW'(NP + p)) af_raw[p*WORD_W +: WORD_W] <= din;
        end
        slot_q <= (slot_q == SLW'(NSLOT - 1)) ? '0 : slot_q + SLW'(1);
      end
    end else begin
      slot_q <= '0;
    end
  end

  assign ae_off = ae_raw[AW-1:0];
  assign af_off = af_raw[AW-1:0];

  AST_NO_WRITE_WHEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && full) |=> $stable(wbin)); // R3
  AST_LOAD_KEEPS_FIFO: assert property (@(posedge clk) disable iff (!rst_n)
    !ld_n |=> $stable(wbin)); // R8
  AST_WCOUNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    wcount <= CW'(DEPTH)); // R5
  AST_WGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(wgray ^ $past(wgray)) <= 1); // R11
endmodule

// File: rtl/dcf_rd_ctrl.sv
module dcf_rd_ctrl #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rd_en_n,
  input  logic          rd_en,
  input  logic [AW:0]   wbin_s,
  input  logic [AW-1:0] ae_off,
  output logic [AW:0]   rbin,
  output logic [AW:0]   rgray,
  output logic          mem_re,
  output logic [AW-1:0] mem_raddr,
  output logic          empty,
  output logic          aempty
);
  localparam int CW = AW + 1;

  function automatic logic [CW-1:0] bin_to_gray(input logic [CW-1:0] b);
    return b ^ (b >> 1);
  endfunction

  function automatic logic [CW-1:0] used_words(input logic [CW-1:0] wp,
                                              input logic [CW-1:0] rp);
    return wp - rp;
  endfunction

  logic          rd_req;
  logic          rd_acc;
  logic [CW-1:0] rbin_nxt;
  logic [CW-1:0] rcount;

  assign rd_req   = !rd_en_n && rd_en;
  assign rd_acc   = rd_req && !empty;
  assign rbin_nxt = rbin + CW'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rbin  <= '0;
      rgray <= '0;
    end else if (rd_acc) begin
      rbin  <= rbin_nxt;
      rgray <= bin_to_gray(rbin_nxt);
    end
  end

  assign mem_re    = rd_acc;
  assign mem_raddr = rbin[AW-1:0];

  assign rcount = used_words(wbin_s, rbin);
  assign empty  = (rcount == '0);
  assign aempty = rcount <= {1'b0, ae_off};

  AST_NO_READ_WHEN_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_req && empty) |=> $stable(rbin)); // R3
  AST_RGRAY_ONE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(rgray ^ $past(rgray)) <= 1); // R11
endmodule

// File: rtl/dcf_fifo_pflag.sv
module dcf_fifo_pflag
  import dcf_pkg::*;
#(
  parameter int DEPTH       = 512,
  parameter int SYNC_STAGES = 2
) (
  input  logic              wr_clk,
  input  logic              rd_clk,
  input  logic              rst_n,
  input  logic              wr_en_n,
  input  logic              wr_en,
  input  logic              ld_n,
  input  logic [WORD_W-1:0] wr_data,
  input  logic              rd_en_n,
  input  logic              rd_en,
  input  logic              oe_n,
  output logic [WORD_W-1:0] rd_data,
  output logic              rd_oe,
  output logic              empty_n,
  output logic              almost_empty_n,
  output logic              almost_full_n,
  output logic              full_n
);
  localparam int AW = $clog2(DEPTH);

  logic [AW:0]       wbin, wgray, rbin, rgray;
  logic [AW:0]       wbin_s, rbin_s;
  logic              mem_we, mem_re;
  logic [AW-1:0]     mem_waddr, mem_raddr;
  logic [WORD_W-1:0] mem_q;
  logic              full, afull, empty, aempty;
  logic [AW-1:0]     ae_off, af_off;

  dcf_wr_ctrl #(.AW(AW)) u_wr (
    .clk(wr_clk), .rst_n(rst_n), .wr_en_n(wr_en_n), .wr_en(wr_en),
    .ld_n(ld_n), .din(wr_data), .rbin_s(rbin_s), .wbin(wbin),
    .wgray(wgray), .mem_we(mem_we), .mem_waddr(mem_waddr),
    .full(full), .afull(afull), .ae_off(ae_off), .af_off(af_off)
  );

  dcf_rd_ctrl #(.AW(AW)) u_rd (
    .clk(rd_clk), .rst_n(rst_n), .rd_en_n(rd_en_n), .rd_en(rd_en),
    .wbin_s(wbin_s), .ae_off(ae_off), .rbin(rbin), .rgray(rgray),
    .mem_re(mem_re), .mem_raddr(mem_raddr), .empty(empty), .aempty(aempty)
  );

  dcf_gray_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_w2r (
    .clk(rd_clk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_s)
  );

  dcf_gray_sync #(.W(AW + 1), .STAGES(SYNC_STAGES)) u_r2w (
    .clk(wr_clk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_s)
  );

  dcf_mem #(.AW(AW), .W(WORD_W)) u_mem (
    .wclk(wr_clk), .we(mem_we), .waddr(mem_waddr), .wdata(wr_data),
    .rclk(rd_clk), .rst_n(rst_n), .re(mem_re), .raddr(mem_raddr),
    .rdata(mem_q)
  );

  assign rd_oe          = !oe_n;
  assign rd_data        = oe_n ? '0 : mem_q;
  assign empty_n        = !empty;
  assign almost_empty_n = !aempty;
  assign full_n         = !full;
  assign almost_full_n  = !afull;

  AST_FULL_IMPLIES_AF: assert property (@(posedge wr_clk) disable iff (!rst_n)
    !full_n |-> !almost_full_n); // R7
  AST_EMPTY_IMPLIES_AE: assert property (@(posedge rd_clk) disable iff (!rst_n)
    !empty_n |-> !almost_empty_n); // R6
endmodule

// File: tb/dcf_fifo_pflag_tb_top.sv
module dcf_fifo_pflag_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int RD_PERIOD  = CLK_PERIOD + 4;
  localparam int DEPTH      = 512;
  localparam int AW         = $clog2(DEPTH);
  localparam int NPB        = (AW + 8) / 9;

  logic       wr_clk = 0, rd_clk = 0, rst_n = 0;
  logic       wr_en_n = 1, wr_en = 0, ld_n = 1;
  logic [8:0] wr_data = '0;
  logic       rd_en_n = 1, rd_en = 0, oe_n = 0;
  logic [8:0] rd_data;
  logic       rd_oe, empty_n, almost_empty_n, almost_full_n, full_n;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [8:0] sb_q[$];
  bit pending = 0;

  always #(CLK_PERIOD/2) wr_clk = ~wr_clk;
  always #(RD_PERIOD/2)  rd_clk = ~rd_clk;

  dcf_fifo_pflag #(.DEPTH(DEPTH)) dut_i (
    .wr_clk(wr_clk), .rd_clk(rd_clk), .rst_n(rst_n), .wr_en_n(wr_en_n),
    .wr_en(wr_en), .ld_n(ld_n), .wr_data(wr_data), .rd_en_n(rd_en_n),
    .rd_en(rd_en), .oe_n(oe_n), .rd_data(rd_data), .rd_oe(rd_oe),
    .empty_n(empty_n), .almost_empty_n(almost_empty_n),
    .almost_full_n(almost_full_n), .full_n(full_n)
  );

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // expected items: a word is accepted when both enables, no load, not full (R1, R3)
  always @(negedge wr_clk) begin
    if (rst_n && wr_en && !wr_en_n && ld_n && full_n) sb_q.push_back(wr_data);
  end

  // monitor: compare the word produced by the previous read edge (R2)
  always @(negedge rd_clk) begin
    if (!rst_n) pending = 0;
    else begin
      if (pending) begin
        if (sb_q.size() == 0) check("R2 unexpected pop", 1, 0);
        else check("R2 read order", int'(rd_data), int'(sb_q.pop_front()));
      end
      pending = rd_en && !rd_en_n && empty_n;
    end
  end

  task automatic wr_push(input logic [8:0] d);
    @(posedge wr_clk); #1;
    wr_data = d; wr_en = 1; wr_en_n = 0;
    @(posedge wr_clk); #1;
    wr_en = 0; wr_en_n = 1;
  endtask

  task automatic rd_pop();
    @(posedge rd_clk); #1;
    rd_en = 1; rd_en_n = 0;
    @(posedge rd_clk); #1;
    rd_en = 0; rd_en_n = 1;
    @(negedge rd_clk); #1;
  endtask

  task automatic settle();
    repeat (4) @(posedge rd_clk);
    repeat (4) @(posedge wr_clk);
    #1;
  endtask

  task automatic do_reset();
    rst_n = 0;
    sb_q.delete();
    repeat (3) @(posedge wr_clk);
    #1;
  endtask

  initial begin
    repeat (150000) @(posedge wr_clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    do_reset();
    // R10 reset state
    check("R10 empty_n", empty_n, 0);
    check("R10 almost_empty_n", almost_empty_n, 0);
    check("R10 full_n", full_n, 1);
    check("R10 almost_full_n", almost_full_n, 1);
    rst_n = 1;
    settle();

    // R4 empty flag crossing
    wr_push(9'h0A5);
    settle();
    check("R4 empty_n after write", empty_n, 1);
    rd_pop();
    check("R4 empty_n after last read", empty_n, 0);

    // R1 one enable alone stores nothing
    @(posedge wr_clk); #1; wr_en = 1; wr_en_n = 1;
    repeat (2) @(posedge wr_clk); #1; wr_en = 0; wr_en_n = 0;
    repeat (2) @(posedge wr_clk); #1; wr_en_n = 1;
    settle();
    check("R1 single enable ignored", empty_n, 0);

    // R3 read while empty is ignored, next word still correct
    rd_pop();
    wr_push(9'h111);
    settle();
    @(posedge rd_clk); #1; rd_en = 1; rd_en_n = 1;     // R2 single read enable
    repeat (2) @(posedge rd_clk); #1; rd_en = 0;
    check("R2 single read enable keeps word", empty_n, 1);
    rd_pop();
    check("R3 queue drained", sb_q.size(), 0);

    // R6 almost empty with default offset 7
    for (int i = 0; i < 8; i++) wr_push(9'(i * 3 + 1));
    settle();
    check("R6 count 8 above offset", almost_empty_n, 1);
    rd_pop();
    check("R6 count 7 at offset", almost_empty_n, 0);
    for (int i = 0; i < 7; i++) rd_pop();
    check("R6 drained empty", empty_n, 0);

    // R9 output enable
    wr_push(9'h1C3);
    settle();
    rd_pop();
    oe_n = 1; #1;
    check("R9 rd_oe off", rd_oe, 0);
    check("R9 rd_data zero", int'(rd_data), 0);
    oe_n = 0; #1;
    check("R9 rd_oe on", rd_oe, 1);
    check("R9 rd_data restored", int'(rd_data), 'h1C3);

    // R5 / R7 fill to full
    for (int i = 0; i < DEPTH; i++) begin
      wr_push(9'(i) ^ 9'h155);
      if (i + 1 == DEPTH - 8) check("R7 free 8", almost_full_n, 1);
      if (i + 1 == DEPTH - 7) check("R7 free 7", almost_full_n, 0);
      if (i + 1 == DEPTH - 1) check("R5 one below full", full_n, 1);
      if (i + 1 == DEPTH)     check("R5 full", full_n, 0);
    end
    wr_push(9'h0FF);   // R3 dropped while full
    check("R3 still full", full_n, 0);
    settle();
    for (int i = 0; i < DEPTH; i++) rd_pop();
    settle();
    check("R3 empty after drain", empty_n, 0);
    check("R3 no extra word", sb_q.size(), 0);

    // R8 offset load: almost-empty 20, almost-full 500
    @(posedge wr_clk); #1; ld_n = 0;
    for (int p = 0; p < NPB; p++) wr_push(9'((20 >> (9 * p)) & 'h1FF));
    for (int p = 0; p < NPB; p++) wr_push(9'((500 >> (9 * p)) & 'h1FF));
    @(posedge wr_clk); #1; ld_n = 1;
    settle();
    check("R8 load writes no word", empty_n, 0);
    for (int i = 0; i < 11; i++) wr_push(9'(i + 40));
    check("R8 free 501 above af offset", almost_full_n, 1);
    wr_push(9'd51);
    check("R8 free 500 at af offset", almost_full_n, 0);
    for (int i = 0; i < 8; i++) wr_push(9'(i + 60));
    settle();
    check("R8 count 20 at ae offset", almost_empty_n, 0);
    wr_push(9'd99);
    settle();
    check("R8 count 21 above ae offset", almost_empty_n, 1);
    for (int i = 0; i < 21; i++) rd_pop();

    // R10 reset mid-run restores flags and default offsets
    for (int i = 0; i < 3; i++) wr_push(9'(i + 7));
    settle();
    do_reset();
    check("R10 empty_n mid-run", empty_n, 0);
    check("R10 full_n mid-run", full_n, 1);
    rst_n = 1;
    settle();
    for (int i = 0; i < 8; i++) wr_push(9'(i + 200));
    settle();
    check("R10 default ae offset count 8", almost_empty_n, 1);
    rd_pop();
    check("R10 default ae offset count 7", almost_empty_n, 0);
    for (int i = 0; i < 7; i++) rd_pop();
    check("R2 queue empty at end", sb_q.size(), 0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule